// File: doc/BRIEF.md
# Programmable 1-bit delay line controller

This block delays a one-bit sample stream, such as the output of a delta modulator, by a selectable number of milliseconds. The stream is kept in a single fixed bit store organised as a circular buffer. A 4-bit delay code sets two things at once: how fast samples are taken and how many bit slots of the store are in use. Sixteen equally spaced delays therefore come out of one store size. With the default parameters the store holds 49152 bits. The master clock is divided by 4 for the fast rate and by 8 for the slow rate. From a 2 MHz clock that gives 500 kHz and 250 kHz. The sixteen delays then run from about 12.3 ms to about 196.6 ms.

The block generates a sample strobe from the master clock. On each strobe it reads the oldest stored bit, presents it as the delayed output and writes the new input bit into the same slot. A sleep input freezes the divider, the pointer, the store and the output. A change of delay code restarts the buffer. The output is held low until the new buffer length has been completely rewritten, so stale bits from an earlier setting never reach the output.

Top module: `dly_line_ctrl`

## Requirements
- R1: While `rst_ni` is low, `dout_o` is 0 and `stb_o` is 0.
- R2: Awake strobes on `stb_o` are spaced exactly FAST_DIV clock cycles apart when `code_i[3]` is 0 and SLOW_DIV cycles apart when `code_i[3]` is 1 (defaults 4 and 8).
- R3: For codes 0 to 7, the buffer length is L = (code+1)·BASE_LEN samples. Once primed, the output after strobe k equals the input bit taken at strobe k−L.
- R4: For codes 8 to 15, the buffer length is L = (code+1)·BASE_LEN/2 samples, with the same delay relation as R3.
- R5: `din_i` is sampled at the clock edge that ends a cycle in which `stb_o` is high. `dout_o` changes only at such an edge, or at a restart.
- R6: After a restart, the first L strobes drive `dout_o` low, whatever the store held before.
- R7: When `code_i` differs from the active code while awake, the next edge restarts the buffer. `stb_o` is low in that cycle, `dout_o` is cleared at that edge, the pointer returns to slot 0, and the first strobe follows exactly one divider period later.
- R8: While `sleep_i` is high, `stb_o` is low, and `dout_o`, the pointer and the divider hold. After wake-up, strobe spacing and delay history continue where they stopped.
- R9: A code change made while `sleep_i` is high takes effect only in the first awake cycle, with the restart behaviour of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Freeze all activity while high |
| code_i | input | 4 | Delay code; bit 3 selects the slow rate |
| din_i | input | 1 | Input sample bit |
| stb_o | output | 1 | Sample strobe; high for one cycle per sample |
| dout_o | output | 1 | Delayed sample bit |

## Verification
- **Wrong pointer wrap or length:** shows as a mismatch on `dout_o` exactly L strobes after the first bit that was written to the wrong slot. Long random input streams expose it as soon as the buffer turns over.
- **Wrong divider count:** shows at the very next strobe as a gap that differs from the rate's divisor.
- **Wrong primed flag:** shows within one strobe of a restart. The test fills the store with ones and then switches to a shorter buffer, so a leaked stale bit appears as a 1 where a 0 is expected.
- **Frozen state leaking during sleep:** shows as a strobe or an output change within the sleep window, or as a shifted gap or delay right after wake-up.

// File: rtl/dly_line_pkg.sv
package dly_line_pkg;

    // Width of the delay code and number of codes per sample rate.
    localparam int unsigned CODE_W     = 4;
    localparam int unsigned RATE_STEPS = 8;

    // Sample rate selected by the top bit of the delay code.
    typedef enum logic {
        RATE_FAST = 1'b0,
        RATE_SLOW = 1'b1
    } rate_e;

endpackage

// File: rtl/dly_cfg_decode.sv
// Turns a delay code into a sample rate and an active buffer length.
module dly_cfg_decode
    import dly_line_pkg::*;
#(
    parameter int unsigned BASE_LEN = 6144,
    parameter int unsigned LEN_W    = 16
) (
    input  logic [CODE_W-1:0] code_i,
    output rate_e             rate_o,
    output logic [LEN_W-1:0]  len_o
);

    localparam int unsigned HALF_LEN = BASE_LEN / 2;

    logic [LEN_W-1:0] step_w;
    logic [LEN_W-1:0] mult_w;

    always_comb begin
        rate_o = code_i[CODE_W-1] ? RATE_SLOW : RATE_FAST;
        // The slow rate halves the step so the delay keeps rising evenly.
        step_w = (rate_o == RATE_SLOW) ? LEN_W'(HALF_LEN) : LEN_W'(BASE_LEN);
        mult_w = LEN_W'(code_i) + LEN_W'(1);
        len_o  = LEN_W'(mult_w * step_w);
    end

endmodule

// File: rtl/dly_rate_gen.sv
// Divides the master clock down to the sample strobe.
module dly_rate_gen
    import dly_line_pkg::*;
#(
    parameter int unsigned FAST_DIV = 4,
    parameter int unsigned SLOW_DIV = 8
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  rate_e rate_i,
    input  logic  run_i,
    input  logic  restart_i,
    output logic  stb_o
);

    localparam int unsigned MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int unsigned CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } gen_state_t;

    gen_state_t       gen_d, gen_q;
    logic [CNT_W-1:0] last_w;
    logic             stb_w;

    always_comb begin
        last_w = (rate_i == RATE_SLOW) ? CNT_W'(SLOW_DIV - 1) : CNT_W'(FAST_DIV - 1);
        stb_w  = run_i && !restart_i && (gen_q.cnt == last_w);
        gen_d  = gen_q;
        if (restart_i) begin
            gen_d.cnt = '0;
        end else if (run_i) begin
            gen_d.cnt = stb_w ? '0 : gen_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign stb_o = stb_w;

endmodule

// File: rtl/dly_ring_ptr.sv
// Circular slot pointer that wraps at the active length and records a full pass.
module dly_ring_ptr #(
    parameter int unsigned LEN_W = 16,
    parameter int unsigned PTR_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stb_i,
    input  logic             restart_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             primed_o
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             primed;
    } ptr_state_t;

    ptr_state_t ptr_d, ptr_q;
    logic       wrap_w;

    always_comb begin
        wrap_w = (LEN_W'(ptr_q.ptr) == (len_i - LEN_W'(1)));
        ptr_d  = ptr_q;
        if (restart_i) begin
            ptr_d.ptr    = '0;
            ptr_d.primed = 1'b0;
        end else if (stb_i) begin
            ptr_d.ptr    = wrap_w ? '0 : ptr_q.ptr + PTR_W'(1);
            ptr_d.primed = ptr_q.primed | wrap_w;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr_o    = ptr_q.ptr;
    assign primed_o = ptr_q.primed;

endmodule

// File: rtl/dly_bit_store.sv
// Bit-addressed store built from words: read the old bit, write the new bit in its place.
module dly_bit_store #(
    parameter int unsigned STORE_BITS = 49152,
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned PTR_W      = 16
) (
    input  logic             clk_i,
    input  logic             en_i,
    input  logic [PTR_W-1:0] addr_i,
    input  logic             wbit_i,
    output logic             rbit_o
);

    localparam int unsigned WORDS = STORE_BITS / WORD_W;
    localparam int unsigned SEL_W = $clog2(WORD_W);
    localparam int unsigned IDX_W = PTR_W - SEL_W;

    logic [WORD_W-1:0] mem_q [WORDS];
    logic [IDX_W-1:0]  idx_w;
    logic [SEL_W-1:0]  sel_w;
    logic [WORD_W-1:0] rd_word_w;
    logic [WORD_W-1:0] wr_word_w;

    always_comb begin
        idx_w            = addr_i[PTR_W-1:SEL_W];
        sel_w            = addr_i[SEL_W-1:0];
        rd_word_w        = mem_q[idx_w];
        rbit_o           = rd_word_w[sel_w];
        wr_word_w        = rd_word_w;
        wr_word_w[sel_w] = wbit_i;
    end

    always_ff @(posedge clk_i) begin
        if (en_i) begin
            mem_q[idx_w] <= wr_word_w;
        end
    end

endmodule

// File: rtl/dly_line_ctrl.sv
// Top: code capture, restart control, delayed output register.
module dly_line_ctrl
    import dly_line_pkg::*;
#(
    parameter int unsigned FAST_DIV = 4,
    parameter int unsigned SLOW_DIV = 8,
    parameter int unsigned BASE_LEN = 6144,
    parameter int unsigned WORD_W   = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sleep_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              din_i,
    output logic              stb_o,
    output logic              dout_o
);

    localparam int unsigned STORE_BITS = RATE_STEPS * BASE_LEN;
    localparam int unsigned LEN_W      = $clog2(STORE_BITS + 1);
    localparam int unsigned PTR_W      = $clog2(STORE_BITS);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              dout;
    } top_state_t;

    top_state_t       top_d, top_q;
    rate_e            rate_w;
    logic [LEN_W-1:0] len_w;
    logic [PTR_W-1:0] ptr_w;
    logic             primed_w;
    logic             rbit_w;
    logic             stb_w;
    logic             restart_w;

    // A new code is taken only while awake; during sleep it waits.
    assign restart_w = !sleep_i && (code_i != top_q.code);

    dly_cfg_decode #(
        .BASE_LEN (BASE_LEN),
        .LEN_W    (LEN_W)
    ) i_cfg (
        .code_i (top_q.code),
        .rate_o (rate_w),
        .len_o  (len_w)
    );

    dly_rate_gen #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) i_rate (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rate_i    (rate_w),
        .run_i     (!sleep_i),
        .restart_i (restart_w),
        .stb_o     (stb_w)
    );

    dly_ring_ptr #(
        .LEN_W (LEN_W),
        .PTR_W (PTR_W)
    ) i_ptr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .stb_i     (stb_w),
        .restart_i (restart_w),
        .len_i     (len_w),
        .ptr_o     (ptr_w),
        .primed_o  (primed_w)
    );

    dly_bit_store #(
        .STORE_BITS (STORE_BITS),
        .WORD_W     (WORD_W),
        .PTR_W      (PTR_W)
    ) i_store (
        .clk_i  (clk_i),
        .en_i   (stb_w),
        .addr_i (ptr_w),
        .wbit_i (din_i),
        .rbit_o (rbit_w)
    );

    always_comb begin
        top_d = top_q;
        if (restart_w) begin
            top_d.code = code_i;
            top_d.dout = 1'b0;
        end else if (stb_w) begin
            // Slots not yet rewritten since the restart read as silence.
            top_d.dout = primed_w & rbit_w;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign stb_o  = stb_w;
    assign dout_o = top_q.dout;

endmodule

// File: rtl/dly_line_ctrl_chk.sv
// Property checker bound into the delay line top.
module dly_line_ctrl_chk #(
    parameter int unsigned PTR_W = 16,
    parameter int unsigned LEN_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sleep_i,
    input logic             stb_i,
    input logic             dout_i,
    input logic [PTR_W-1:0] ptr_i,
    input logic [LEN_W-1:0] len_i,
    input logic             primed_i,
    input logic             restart_i
);

    assert_no_stb_asleep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sleep_i |-> !stb_i);

    assert_hold_asleep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sleep_i |=> ($stable(dout_i) && $stable(ptr_i)));

    assert_ptr_in_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        LEN_W'(ptr_i) < len_i);

    assert_stb_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_i |=> !stb_i);

    assert_unprimed_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stb_i && !primed_i) |=> !dout_i);

    assert_restart_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (ptr_i == '0 && !dout_i && !primed_i));

endmodule

bind dly_line_ctrl dly_line_ctrl_chk #(
    .PTR_W (PTR_W),
    .LEN_W (LEN_W)
) i_dly_line_ctrl_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sleep_i   (sleep_i),
    .stb_i     (stb_o),
    .dout_i    (dout_o),
    .ptr_i     (ptr_w),
    .len_i     (len_w),
    .primed_i  (primed_w),
    .restart_i (restart_w)
);

// File: tb/test_dly_line_ctrl.sv
module test_dly_line_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int TB_BASE    = 16;
    localparam int TB_WORD    = 8;
    localparam int TB_FAST    = 4;
    localparam int TB_SLOW    = 8;

    logic       clk = 1'b0;
    logic       rst_ni;
    logic       sleep_i;
    logic [3:0] code_i;
    logic       din_i;
    logic       stb_o;
    logic       dout_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dly_line_ctrl #(
        .FAST_DIV (TB_FAST),
        .SLOW_DIV (TB_SLOW),
        .BASE_LEN (TB_BASE),
        .WORD_W   (TB_WORD)
    ) i_dly_line_ctrl (
        .clk_i   (clk),
        .rst_ni  (rst_ni),
        .sleep_i (sleep_i),
        .code_i  (code_i),
        .din_i   (din_i),
        .stb_o   (stb_o),
        .dout_o  (dout_o)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    int    k = 0;
    int    st_total = 0;
    int    m_code = 0;
    int    m_len = TB_BASE;
    int    m_div = TB_FAST;
    int    last_stb = 0;
    bit    hist [1024];
    bit    exp_out = 1'b0;
    string exp_tag = "R1";
    string first_tag = "R7";
    bit    code_pending = 1'b0;
    bit    din_ones = 1'b0;
    bit    prev_sleep = 1'b0;
    bit    prev_event = 1'b1;
    logic  prev_dout = 1'b0;

    function automatic int len_of(int c);
        return (c < 8) ? (c + 1) * TB_BASE : (c + 1) * (TB_BASE / 2);
    endfunction

    function automatic int div_of(int c);
        return (c < 8) ? TB_FAST : TB_SLOW;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // One clock cycle: check outputs, drive inputs, follow the reference model.
    task automatic tick(bit sl, int c);
        @(negedge clk);
        cyc++;
        check(dout_o === exp_out, exp_tag, int'(dout_o), int'(exp_out));
        if (prev_sleep)
            check(dout_o === prev_dout, "R8", int'(dout_o), int'(prev_dout));
        else if (!prev_event)
            check(dout_o === prev_dout, "R5", int'(dout_o), int'(prev_dout));
        prev_dout = dout_o;
        sleep_i = sl;
        code_i  = 4'(c);
        din_i   = din_ones ? 1'b1 : 1'($urandom);
        #1;
        prev_event = 1'b0;
        prev_sleep = sl;
        if (!sl && c != m_code) begin
            first_tag = code_pending ? "R9" : "R7";
            check(stb_o === 1'b0, first_tag, int'(stb_o), 0);
            code_pending = 1'b0;
            m_code   = c;
            m_len    = len_of(c);
            m_div    = div_of(c);
            k        = 0;
            exp_out  = 1'b0;
            exp_tag  = "R7";
            last_stb = cyc;
            prev_event = 1'b1;
        end else if (sl) begin
            check(stb_o === 1'b0, "R8", int'(stb_o), 0);
            last_stb++;
            if (c != m_code) code_pending = 1'b1;
        end else if (stb_o === 1'b1) begin
            check(cyc - last_stb == m_div, first_tag, cyc - last_stb, m_div);
            first_tag = "R2";
            last_stb  = cyc;
            hist[k]   = din_i;
            if (k >= m_len) begin
                exp_out = hist[k - m_len];
                exp_tag = (m_code < 8) ? "R3" : "R4";
            end else begin
                exp_out = 1'b0;
                exp_tag = "R6";
            end
            k++;
            st_total++;
            prev_event = 1'b1;
        end
    endtask

    task automatic t_reset();
        rst_ni  = 1'b0;
        sleep_i = 1'b0;
        code_i  = 4'd0;
        din_i   = 1'b0;
        repeat (5) begin
            @(negedge clk);
            #1;
            check(dout_o === 1'b0, "R1", int'(dout_o), 0);
            check(stb_o === 1'b0, "R1", int'(stb_o), 0);
        end
        @(negedge clk);
        rst_ni = 1'b1;
    endtask

    task automatic t_run(int c, int n, bit ones);
        int st0;
        din_ones = ones;
        st0 = st_total;
        while (st_total < st0 + n) tick(1'b0, c);
    endtask

    task automatic t_sleep(int c, int n);
        repeat (n) tick(1'b1, c);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R2: watchdog expired, actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        // R3, R7: fast rate, short buffer, random stream.
        t_run(2, 2 * len_of(2) + 4, 1'b0);
        // R3: smallest buffer.
        t_run(0, 3 * len_of(0), 1'b0);
        // Fill the whole store with ones at the largest fast length.
        t_run(7, len_of(7) + 12, 1'b1);
        // R4, R6: slow rate, shorter buffer; stale ones must not appear.
        t_run(8, 2 * len_of(8) + 6, 1'b0);
        // R4: longest setting.
        t_run(15, 2 * len_of(15) + 4, 1'b0);
        // R8: sleep in the middle of a run, then continue the history.
        t_run(3, len_of(3) + 16, 1'b0);
        t_sleep(3, 25);
        t_run(3, len_of(3) + 10, 1'b0);
        // R9: code change while asleep is deferred to wake-up.
        t_sleep(3, 8);
        t_sleep(12, 8);
        t_run(12, 2 * len_of(12) + 4, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule